// File: doc/BRIEF.md
# Paged I2C Register Slave

This block is a target-side I2C engine that gives an external bus master byte access to a register file inside the chip. SCL and SDA arrive as raw pad samples. They pass through a small synchronizer in the system clock domain, and START, repeated START and STOP are recognised as SDA edges while SCL is high. A transfer begins with an address byte. Its upper seven bits must equal a fixed five-bit prefix followed by two strap pins, and its low bit selects the direction. A write transfer carries a memory-address byte that loads an internal address counter, then any number of data bytes. Each data byte is handed to the register file as a one-cycle write strobe. Writes stay inside one 8-byte row: after the last byte of a row, the counter wraps back to the start of that same row. A read transfer streams bytes from the register file, starting at the current counter value.

A write that ends with STOP must be saved to the nonvolatile copy. The block reports this with a one-cycle commit pulse. A timer then models the save time, and while it runs the slave declines its own address so that the master can poll with acknowledges. A write that ends with a repeated START changes only the volatile registers. The register file sits outside the block and answers a read through a combinational read-data input indexed by the address output.

The state machine has ten states:
- IDLE waits for START.
- ADDR shifts in the address byte. On the eighth falling SCL edge it moves to ADDR_ACK when the address matches and the commit timer is idle; otherwise it moves to SKIP.
- ADDR_ACK moves to MADDR for a write or to RDATA for a read.
- MADDR takes the memory-address byte and moves to MADDR_ACK, which moves to WDATA.
- WDATA takes data bytes and moves to WDATA_ACK, which returns to WDATA.
- RDATA drives a byte and moves to RACK. RACK returns to RDATA on a master ACK and goes to SKIP on a NACK.
- SKIP stays put.

START moves every state to ADDR, and STOP moves every state to IDLE.

Top module: `i2c_paged_regslave`

## Requirements
- R1: SDA falling while SCL is high (START or repeated START) restarts address reception from any state. SDA rising while SCL is high (STOP) returns the slave to idle.
- R2: The address byte is received MSB first. Bits 7..1 must equal binary 01010 followed by strap_i[1] and strap_i[0], and bit 0 is the direction (0 write, 1 read). A matching address is acknowledged by pulling SDA low during the ninth clock of the byte.
- R3: In a write transfer, the byte after the address byte is the memory address. It is acknowledged and loaded into the address counter, which appears on reg_addr_o.
- R4: Each later write byte gives exactly one reg_wr_en_o cycle carrying the byte on reg_wdata_o and the counter on reg_addr_o. The counter then increments within its 8-byte row: bits 7..3 are kept, and bits 2..0 wrap from 7 to 0.
- R5: A read transfer starts at the current counter value and returns bytes MSB first. The counter advances by one (modulo 256, across row edges) after each byte. A master ACK (0) continues the read; a master NACK (1) makes the slave release SDA until the next START.
- R6: After an address mismatch the slave never drives SDA and issues no write strobe until the next START.
- R7: A STOP that ends a transfer in which at least one data byte was written gives a single commit_start_o pulse, and commit_busy_o is then high for exactly COMMIT_CYCLES cycles. A write ended by a repeated START, and any transfer without written data, gives no pulse.
- R8: While commit_busy_o is high, the slave's own address is not acknowledged and no write strobe occurs.
- R9: After reset, SDA is released, there is no strobe and no commit pulse, busy is low, and the address counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad (wired-AND bus value) |
| strap_i | input | 2 | Address strap pins, forming the two low address bits |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it (open drain) |
| reg_addr_o | output | 8 | Address counter toward the register file |
| reg_wdata_o | output | 8 | Write data toward the register file |
| reg_wr_en_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Read data for reg_addr_o, combinational from the register file |
| commit_start_o | output | 1 | One-cycle pulse: written data must be saved to nonvolatile storage |
| commit_busy_o | output | 1 | Nonvolatile save time running; own address is NACKed |

## Verification
The assertions assume that SDA changes only while SCL is low, except for intentional START and STOP conditions. They also assume that each SCL level lasts longer than the synchronizer delay, so that every edge is seen once, in order. The bench master keeps each SCL phase four system clocks long, well above the three-cycle detection delay. It changes SDA only in the low phase and produces START and STOP only with SCL held high. The register file model answers within the same cycle, as the read path expects.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_MADDR,
        ST_MADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_SKIP
    } slv_state_t;
endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;
    logic scl_s, scl_p, sda_s, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign scl_p = scl_pipe[STAGES];
    assign sda_s = sda_pipe[STAGES-1];
    assign sda_p = sda_pipe[STAGES];

    assign sda_q     = sda_s;
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cs_addr_ctr.sv
module i2cs_addr_ctr #(
    parameter int AW        = 8,
    parameter int ROW_BYTES = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc_row,
    input  logic          inc_lin,
    output logic [AW-1:0] addr
);
    localparam int RB = $clog2(ROW_BYTES);

    logic [RB-1:0] low_next;
    assign low_next = addr[RB-1:0] + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       addr <= '0;
        else if (load)    addr <= load_val;
        else if (inc_row) addr <= {addr[AW-1:RB], low_next};
        else if (inc_lin) addr <= addr + 1'b1;
    end

    assert_row_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_row && !load) |=> (addr[AW-1:RB] == $past(addr[AW-1:RB])));
endmodule

// File: rtl/i2cs_commit_timer.sv
module i2cs_commit_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           remain <= '0;
        else if (kick)        remain <= CW'(CYCLES);
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign busy = (remain != 0);

    assert_kick_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> busy);
endmodule

// File: rtl/i2c_paged_regslave.sv
module i2c_paged_regslave
    import i2cs_pkg::*;
#(
    parameter logic [4:0] ADDR_PREFIX   = 5'b01010,
    parameter int         ROW_BYTES     = 8,
    parameter int         COMMIT_CYCLES = 64,
    parameter int         SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [1:0] strap_i,
    output logic       sda_oe_o,
    output logic [7:0] reg_addr_o,
    output logic [7:0] reg_wdata_o,
    output logic       reg_wr_en_o,
    input  logic [7:0] reg_rdata_i,
    output logic       commit_start_o,
    output logic       commit_busy_o
);
    localparam int BYTE_BITS = 8;
    localparam int CNT_W     = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

    slv_state_t state, nxt;

    logic             sda_q, scl_rise, scl_fall, start_det, stop_det;
    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       shreg;
    logic [7:0]       rbuf;
    logic             rw_q, mnack, dirty;
    logic             addr_hit, byte_done;
    logic             ctr_load, ctr_inc_row, ctr_inc_lin, commit_kick;

    i2cs_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    assign addr_hit    = (shreg[7:1] == {ADDR_PREFIX, strap_i}) && !commit_busy_o;
    assign byte_done   = scl_fall && (bit_cnt == LAST_BIT);
    assign ctr_load    = (state == ST_MADDR) && byte_done;
    assign ctr_inc_row = (state == ST_WDATA_ACK) && scl_fall;
    assign ctr_inc_lin = (state == ST_RDATA) && byte_done;
    assign commit_kick = stop_det && dirty;

    i2cs_addr_ctr #(.AW(8), .ROW_BYTES(ROW_BYTES)) ctr_i (
        .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(shreg),
        .inc_row(ctr_inc_row), .inc_lin(ctr_inc_lin), .addr(reg_addr_o)
    );

    i2cs_commit_timer #(.CYCLES(COMMIT_CYCLES)) tmr_i (
        .clk(clk), .rst_n(rst_n), .kick(commit_kick), .busy(commit_busy_o)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      nxt = ST_IDLE;
            ST_ADDR:      if (byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_SKIP;
            ST_ADDR_ACK:  if (scl_fall)  nxt = rw_q ? ST_RDATA : ST_MADDR;
            ST_MADDR:     if (byte_done) nxt = ST_MADDR_ACK;
            ST_MADDR_ACK: if (scl_fall)  nxt = ST_WDATA;
            ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
            ST_WDATA_ACK: if (scl_fall)  nxt = ST_WDATA;
            ST_RDATA:     if (byte_done) nxt = ST_RACK;
            ST_RACK:      if (scl_fall)  nxt = mnack ? ST_SKIP : ST_RDATA;
            ST_SKIP:      nxt = ST_SKIP;
            default:      nxt = ST_IDLE;
        endcase
        if (start_det)     nxt = ST_ADDR;
        else if (stop_det) nxt = ST_IDLE;
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt        <= '0;
            shreg          <= '0;
            rbuf           <= '0;
            rw_q           <= 1'b0;
            mnack          <= 1'b0;
            dirty          <= 1'b0;
            reg_wr_en_o    <= 1'b0;
            commit_start_o <= 1'b0;
        end else begin
            reg_wr_en_o    <= 1'b0;
            commit_start_o <= 1'b0;
            if (start_det) begin
                bit_cnt <= '0;
                dirty   <= 1'b0;
            end else if (stop_det) begin
                commit_start_o <= dirty;
                dirty          <= 1'b0;
            end else begin
                if (scl_rise) begin
                    if (state == ST_ADDR || state == ST_MADDR || state == ST_WDATA) begin
                        shreg   <= {shreg[6:0], sda_q};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                    if (state == ST_RDATA) bit_cnt <= bit_cnt + 1'b1;
                    if (state == ST_RACK)  mnack <= sda_q;
                end
                if (scl_fall) begin
                    if (state == ST_ADDR && byte_done) rw_q <= shreg[0];
                    if (state == ST_WDATA && byte_done) begin
                        reg_wr_en_o <= 1'b1;
                        dirty       <= 1'b1;
                    end
                    if (state == ST_ADDR_ACK || state == ST_MADDR_ACK || state == ST_WDATA_ACK)
                        bit_cnt <= '0;
                    if ((state == ST_ADDR_ACK && rw_q) || (state == ST_RACK && !mnack)) begin
                        rbuf    <= reg_rdata_i;
                        bit_cnt <= '0;
                    end
                    if (state == ST_RDATA && !byte_done) rbuf <= {rbuf[6:0], 1'b0};
                end
            end
        end
    end

    assign reg_wdata_o = shreg;
    assign sda_oe_o    = (state == ST_ADDR_ACK) || (state == ST_MADDR_ACK) ||
                         (state == ST_WDATA_ACK) || ((state == ST_RDATA) && !rbuf[7]);

    assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));
    assert_stop_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));
    assert_skip_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!sda_oe_o && !reg_wr_en_o));
    assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en_o |=> !reg_wr_en_o);
    assert_commit_after_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        commit_start_o |-> ($past(stop_det) && commit_busy_o));
    assert_busy_no_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> !commit_busy_o);
endmodule

// File: tb/i2c_paged_regslave_tb.sv
module i2c_paged_regslave_tb_top;
    localparam int Q      = 4;
    localparam int CYC    = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       sda_oe, wr_en, c_start, c_busy;
    logic [7:0] raddr, wdata, rdata;
    logic       sda_bus;

    logic [7:0] mem [256];
    logic [7:0] expm [256];

    int checks = 0, failures = 0;
    int wr_count = 0, commits = 0, busy_run = 0, oe_in_skip = 0;
    bit skip_win = 1'b0, done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;
    assign rdata   = mem[raddr];

    i2c_paged_regslave #(.COMMIT_CYCLES(CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .strap_i(strap),
        .sda_oe_o(sda_oe), .reg_addr_o(raddr), .reg_wdata_o(wdata), .reg_wr_en_o(wr_en),
        .reg_rdata_i(rdata), .commit_start_o(c_start), .commit_busy_o(c_busy)
    );

    always @(posedge clk) if (wr_en) mem[raddr] <= wdata;

    always @(negedge clk) begin
        if (wr_en) wr_count++;
        if (c_start) begin commits++; busy_run = 1; end
        else if (c_busy) busy_run++;
        if (skip_win && sda_oe) oe_in_skip++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tk(Q); m_scl = 1'b1; tk(Q); m_sda = 1'b0; tk(Q); m_scl = 1'b0; tk(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tk(Q); m_scl = 1'b1; tk(Q); m_sda = 1'b1; tk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tk(Q); m_scl = 1'b1; tk(2*Q); m_scl = 1'b0; tk(Q);
        end
        m_sda = 1'b1; tk(Q); m_scl = 1'b1; tk(Q); ack = ~sda_bus; tk(Q); m_scl = 1'b0; tk(Q);
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tk(Q); m_scl = 1'b1; tk(Q); b[i] = sda_bus; tk(Q); m_scl = 1'b0; tk(Q);
        end
        m_sda = nack; tk(Q); m_scl = 1'b1; tk(2*Q); m_scl = 1'b0; tk(Q);
        m_sda = 1'b1;
    endtask

    function automatic logic [7:0] own_addr(input logic [1:0] s, input logic rd);
        return {5'b01010, s, rd};
    endfunction

    initial begin
        logic ack;
        logic [7:0] b;
        int c0, w0;
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'((i * 37 + 11) & 255);
            expm[i] = 8'((i * 37 + 11) & 255);
        end
        tk(5); rst_n = 1'b1; tk(4);

        // R9 reset state
        chk(sda_oe == 0, "R9 sda released", sda_oe, 0);
        chk(wr_en == 0 && c_start == 0, "R9 no strobe", wr_en, 0);
        chk(c_busy == 0, "R9 busy low", c_busy, 0);
        chk(raddr == 0, "R9 counter zero", raddr, 0);

        // R2/R6 address sweep with strap = 2'b10
        strap = 2'b10;
        for (int a = 0; a < 128; a++) begin
            bit hit;
            hit = (a == {5'b01010, 2'b10});
            w0 = wr_count;
            bus_start();
            send_byte({7'(a), 1'b0}, ack);
            chk(ack == hit, "R2 address match ack", ack, hit);
            if (!hit) begin
                oe_in_skip = 0; skip_win = 1'b1;
                send_byte(8'h00, ack);
                send_byte(8'h00, ack);
                skip_win = 1'b0;
                chk(oe_in_skip == 0 && wr_count == w0, "R6 silent after mismatch", oe_in_skip, 0);
            end
            bus_stop();
        end
        chk(commits == 0, "R7 no commit without data", commits, 0);

        // R2/R7 strap sweep, one committed byte each
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            c0 = commits;
            bus_start();
            send_byte(own_addr(2'(s), 1'b0), ack);
            chk(ack == 1, "R2 strap address ack", ack, 1);
            send_byte(8'(8'h40 + s), ack);
            send_byte(8'(8'hC0 + s), ack);
            expm[8'h40 + s] = 8'(8'hC0 + s);
            bus_stop();
            tk(4);
            chk(commits == c0 + 1, "R7 commit on stop", commits, c0 + 1);
            tk(CYC + 10);
            chk(busy_run == CYC, "R7 busy length", busy_run, CYC);
        end
        strap = 2'b00;

        // R3/R4 page wrap write, ended by repeated START
        c0 = commits; w0 = wr_count;
        bus_start();
        send_byte(own_addr(2'b00, 1'b0), ack);
        send_byte(8'h1D, ack);
        chk(ack == 1, "R3 memory address ack", ack, 1);
        for (int k = 0; k < 5; k++) begin
            logic [7:0] ad;
            ad = {5'b00011, 3'(3'd5 + k)};
            send_byte(8'(8'hA0 + k), ack);
            chk(ack == 1, "R4 data ack", ack, 1);
            expm[ad] = 8'(8'hA0 + k);
        end
        chk(wr_count == w0 + 5, "R4 strobe count", wr_count, w0 + 5);
        // repeated START then current-address read: counter sits at 0x1A
        bus_start();
        send_byte(own_addr(2'b00, 1'b1), ack);
        for (int k = 0; k < 3; k++) begin
            recv_byte(k == 2, b);
            chk(b == expm[8'h1A + k], "R4 wrapped counter read", b, expm[8'h1A + k]);
        end
        bus_stop();
        tk(4);
        chk(commits == c0, "R7 repeated start no commit", commits, c0);
        for (int k = 0; k < 8; k++)
            chk(mem[8'h18 + k] == expm[8'h18 + k], "R4 row contents", mem[8'h18 + k], expm[8'h18 + k]);
        chk(mem[8'h20] == expm[8'h20], "R4 next row untouched", mem[8'h20], expm[8'h20]);

        // R5 sequential read across a row edge
        bus_start();
        send_byte(own_addr(2'b00, 1'b0), ack);
        send_byte(8'h1E, ack);
        bus_start();
        send_byte(own_addr(2'b00, 1'b1), ack);
        for (int k = 0; k < 4; k++) begin
            recv_byte(k == 3, b);
            chk(b == expm[8'h1E + k], "R5 sequential read", b, expm[8'h1E + k]);
        end
        bus_stop();
        bus_start();
        send_byte(own_addr(2'b00, 1'b1), ack);
        recv_byte(1'b1, b);
        chk(b == expm[8'h22], "R5 current address read", b, expm[8'h22]);
        bus_stop();
        chk(sda_oe == 0, "R5 released after nack", sda_oe, 0);

        // R5 read wraps 0xFF -> 0x00
        bus_start();
        send_byte(own_addr(2'b00, 1'b0), ack);
        send_byte(8'hFF, ack);
        bus_start();
        send_byte(own_addr(2'b00, 1'b1), ack);
        recv_byte(1'b0, b);
        chk(b == expm[8'hFF], "R5 read at FF", b, expm[8'hFF]);
        recv_byte(1'b1, b);
        chk(b == expm[8'h00], "R5 read wraps to 00", b, expm[8'h00]);
        bus_stop();

        // R7/R8 commit, then acknowledge polling
        c0 = commits;
        bus_start();
        send_byte(own_addr(2'b00, 1'b0), ack);
        send_byte(8'h30, ack);
        send_byte(8'h5C, ack);
        expm[8'h30] = 8'h5C;
        bus_stop();
        tk(2);
        chk(commits == c0 + 1, "R7 commit pulse", commits, c0 + 1);
        w0 = wr_count;
        bus_start();
        send_byte(own_addr(2'b00, 1'b0), ack);
        chk(ack == 0, "R8 nack while busy", ack, 0);
        send_byte(8'h31, ack);
        send_byte(8'h77, ack);
        bus_stop();
        chk(wr_count == w0, "R8 no write while busy", wr_count, w0);
        chk(commits == c0 + 1, "R8 no extra commit", commits, c0 + 1);
        tk(CYC);
        chk(c_busy == 0, "R7 busy ends", c_busy, 0);
        bus_start();
        send_byte(own_addr(2'b00, 1'b0), ack);
        chk(ack == 1, "R8 ack after busy", ack, 1);
        bus_stop();

        // R1 START mid-byte restarts address reception
        bus_start();
        send_byte(own_addr(2'b00, 1'b0), ack);
        for (int i = 0; i < 3; i++) begin
            m_sda = 1'b1; tk(Q); m_scl = 1'b1; tk(2*Q); m_scl = 1'b0; tk(Q);
        end
        bus_start();
        send_byte(own_addr(2'b00, 1'b1), ack);
        chk(ack == 1, "R1 restart mid byte", ack, 1);
        recv_byte(1'b1, b);
        chk(b == expm[8'h31], "R1 read after restart", b, expm[8'h31]);
        bus_stop();

        for (int i = 0; i < 256; i++)
            if (mem[i] != expm[i]) chk(1'b0, "R4 memory image", mem[i], expm[i]);
        chk(1'b1, "R4 memory image done", 0, 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule